// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the serial-bus front end of a small non-volatile byte memory. As the master sends data bytes in a write transfer, the front end hands each byte over with a one-cycle strobe, together with the seven-bit word address of the transfer. The block gathers up to four bytes in a page buffer. The buffer is tagged with the page base taken from the word address. A per-slot valid mask records which positions really received data.

Nothing reaches the memory array until the front end reports the stop condition. At that point, if at least one byte is buffered, the block runs a commit. It sweeps the four slots in ascending order, one per clock, and drives a write-port strobe only for the valid ones. It then waits a parameterised number of clocks that stands for the self-timed programming cycle. For the whole commit a busy flag is high, and the block ignores every strobe from the bus side. A new start condition empties the buffer. A transfer that carried only an address commits nothing.

Top module: `pwb_page_commit`

## Requirements
- R1: After reset, `busy` and `memWe` are low.
- R2: The first byte after an empty buffer sets the page base to `wordAddr[6:2]` and its slot to `wordAddr[1:0]`. A buffered byte in slot s is written to address {base, s}.
- R3: Each further byte goes to the next slot, counting modulo 4. The page base does not change, so writes never leave the page.
- R4: A fifth or later byte in one transfer overwrites the slot it wraps onto, and the last value wins.
- R5: During a commit, only slots that received a byte are written. They are written in ascending slot order, one byte per clock, and each is written exactly once.
- R6: A stop strobe with at least one buffered byte raises `busy` in the next cycle. `busy` then stays high for exactly 4 + COMMIT_CYCLES cycles.
- R7: A stop strobe with no buffered byte leaves `busy` low and produces no write.
- R8: While `busy` is high, data, start and stop strobes have no effect. A byte offered during the commit is never written.
- R9: A start strobe empties the buffer, so a following stop commits nothing.
- R10: When a commit ends, the buffer is empty, and a further stop without new bytes commits nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | One-cycle strobe: start condition seen on the bus |
| dataValid | input | 1 | One-cycle strobe: a data byte was received |
| byteData | input | 8 | Received data byte, valid with `dataValid` |
| wordAddr | input | 7 | Word address of the current transfer (address byte MSB already dropped) |
| stopPulse | input | 1 | One-cycle strobe: stop condition seen on the bus |
| memWe | output | 1 | Memory array write enable |
| memAddr | output | 7 | Memory array write address |
| memData | output | 8 | Memory array write data |
| busy | output | 1 | Commit in progress; the front end must ignore the master |

## Verification
A wrong slot pointer or page base shows up as data at the wrong array address within four clocks of the stop strobe. A wrong valid mask shows up as an extra or missing write in that same window. A wrong hold counter shows up only when busy falls, as a busy length other than 4 + COMMIT_CYCLES. A buffer that is not cleared stays hidden until a later stop, when it appears as a commit that should not happen. For that reason the bench issues bare stop strobes after each such event and checks the ports.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int PageBytes = 4;
  localparam int SlotW     = $clog2(PageBytes);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_HOLD  = 2'd2
  } pwbState_t;

  typedef struct packed {
    logic             clearBuf;
    logic             takeByte;
    logic             writing;
    logic [SlotW-1:0] slot;
  } pwbStrobes_t;
endpackage

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pwbStrobes_t           ctl,
  input  logic [DATA_W-1:0]     byteData,
  input  logic [ADDR_W-1:0]     wordAddr,
  output logic [PageBytes-1:0]  validMask,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memData
);
  localparam int BaseW = ADDR_W - SlotW;

  logic [DATA_W-1:0] pageBuf [PageBytes];
  logic [BaseW-1:0]  pageBase;
  logic [SlotW-1:0]  fillPtr;
  logic [SlotW-1:0]  targetSlot;
  logic              bufEmpty;

  assign bufEmpty   = (validMask == '0);
  assign targetSlot = bufEmpty ? wordAddr[SlotW-1:0] : fillPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMask <= '0;
      pageBase  <= '0;
      fillPtr   <= '0;
    end else if (ctl.clearBuf) begin
      validMask <= '0;
    end else if (ctl.takeByte) begin
      validMask[targetSlot] <= 1'b1;
      fillPtr               <= targetSlot + 1'b1;
      if (bufEmpty) pageBase <= wordAddr[ADDR_W-1:SlotW];
    end
  end

  for (genvar i = 0; i < PageBytes; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pageBuf[i] <= '0;
      else if (ctl.takeByte && targetSlot == SlotW'(i)) pageBuf[i] <= byteData;
    end
  end

  assign memAddr = {pageBase, ctl.slot};
  assign memData = pageBuf[ctl.slot];

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.takeByte && !bufEmpty) |=> $stable(pageBase)); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearBuf |=> (validMask == '0)); // R9
  AST_BYTE_MARKED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeByte |=> (validMask != '0)); // R2
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int COMMIT_CYCLES = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPulse,
  input  logic                 dataValid,
  input  logic                 stopPulse,
  input  logic [PageBytes-1:0] validMask,
  output pwbStrobes_t          ctl,
  output logic                 memWe,
  output logic                 busy
);
  localparam int CntW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [SlotW-1:0] LastSlot = SlotW'(PageBytes - 1);
  localparam logic [CntW-1:0]  HoldLoad = CntW'(COMMIT_CYCLES - 1);

  pwbState_t        state;
  logic [SlotW-1:0] slotCnt;
  logic [CntW-1:0]  holdCnt;
  logic             idle;
  logic             holdDone;

  assign idle     = (state == ST_IDLE);
  assign holdDone = (state == ST_HOLD) && (holdCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      slotCnt <= '0;
      holdCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (stopPulse && !startPulse && (validMask != '0)) begin
            state   <= ST_WRITE;
            slotCnt <= '0;
          end
        end
        ST_WRITE: begin
          slotCnt <= slotCnt + 1'b1;
          if (slotCnt == LastSlot) begin
            state   <= ST_HOLD;
            holdCnt <= HoldLoad;
          end
        end
        ST_HOLD: begin
          if (holdCnt == '0) state <= ST_IDLE;
          else holdCnt <= holdCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.clearBuf = (idle && startPulse) || holdDone;
    ctl.takeByte = idle && dataValid && !startPulse && !stopPulse;
    ctl.writing  = (state == ST_WRITE);
    ctl.slot     = slotCnt;
  end

  assign memWe = ctl.writing && validMask[slotCnt];
  assign busy  = !idle;

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R5
  AST_STOP_COMMITS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopPulse && !startPulse && (validMask != '0)) |=> busy); // R6
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopPulse && (validMask == '0)) |=> !busy); // R7
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WRITE) && dataValid) |=> $stable(validMask)); // R8
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (validMask == '0)); // R10
endmodule

// File: rtl/pwb_page_commit.sv
module pwb_page_commit
  import pwb_pkg::*;
#(
  parameter int ADDR_W        = 7,
  parameter int DATA_W        = 8,
  parameter int COMMIT_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              stopPulse,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              busy
);
  pwbStrobes_t          ctl;
  logic [PageBytes-1:0] validMask;

  pwb_ctrl #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .dataValid  (dataValid),
    .stopPulse  (stopPulse),
    .validMask  (validMask),
    .ctl        (ctl),
    .memWe      (memWe),
    .busy       (busy)
  );

  pwb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .byteData  (byteData),
    .wordAddr  (wordAddr),
    .validMask (validMask),
    .memAddr   (memAddr),
    .memData   (memData)
  );
endmodule

// File: tb/pwb_page_commit_test.sv
`timescale 1ns/1ps
module pwb_page_commit_test;
  localparam int CYC = 20;
  localparam int BUSY_LEN = 4 + CYC;

  typedef struct packed {
    logic [6:0] addr;
    logic [3:0] n;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{addr: 7'h10, n: 4'd1, seed: 8'hA0},
    '{addr: 7'h13, n: 4'd2, seed: 8'h31},
    '{addr: 7'h05, n: 4'd4, seed: 8'h50},
    '{addr: 7'h7E, n: 4'd6, seed: 8'hC0},
    '{addr: 7'h41, n: 4'd3, seed: 8'h07},
    '{addr: 7'h2A, n: 4'd9, seed: 8'hE1}
  };

  logic clk = 0, rstN = 0;
  logic startPulse = 0, dataValid = 0, stopPulse = 0;
  logic [7:0] byteData = 0;
  logic [6:0] wordAddr = 0;
  logic memWe, busy;
  logic [6:0] memAddr;
  logic [7:0] memData;

  int checks = 0, fails = 0;
  int wrCount = 0;
  bit orderBad = 0;
  bit haveLast = 0;
  logic [6:0] lastAddr;
  logic [7:0] shadow [128];
  logic [7:0] expMem [128];

  always #2.5 clk = ~clk;

  pwb_page_commit #(.COMMIT_CYCLES(CYC)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .dataValid(dataValid),
    .byteData(byteData), .wordAddr(wordAddr), .stopPulse(stopPulse),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .busy(busy)
  );

  always @(posedge clk) begin
    if (!busy) haveLast = 0;
    if (memWe) begin
      shadow[memAddr] = memData;
      wrCount++;
      if (haveLast && memAddr <= lastAddr) orderBad = 1;
      haveLast = 1;
      lastAddr = memAddr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    startPulse = 1; @(negedge clk); startPulse = 0;
  endtask

  task automatic pulseStop();
    stopPulse = 1; @(negedge clk); stopPulse = 0;
  endtask

  task automatic sendByte(input logic [6:0] a, input logic [7:0] d);
    wordAddr = a; byteData = d; dataValid = 1; @(negedge clk); dataValid = 0;
  endtask

  task automatic measureBusy(output int len);
    len = 0;
    while (busy && len < 10 * BUSY_LEN) begin len++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int len, w0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    chk(memWe === 1'b0, "R1 memWe after reset", memWe, 0);
    rstN = 1;
    @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6
    foreach (VECS[k]) begin
      logic [7:0] slotVal [4];
      bit [3:0] slotSet;
      logic [1:0] pos;
      int setCnt;
      slotSet = '0;
      orderBad = 0;
      w0 = wrCount;
      pulseStart();
      for (int i = 0; i < VECS[k].n; i++) begin
        pos = 2'(VECS[k].addr[1:0] + i);
        slotVal[pos] = VECS[k].seed + 8'(i);
        slotSet[pos] = 1'b1;
        sendByte(VECS[k].addr, VECS[k].seed + 8'(i));
      end
      pulseStop();
      chk(busy === 1'b1, "R6 busy after stop", busy, 1);
      measureBusy(len);
      chk(len == BUSY_LEN, "R6 busy length", len, BUSY_LEN);
      setCnt = $countones(slotSet);
      chk(wrCount - w0 == setCnt, "R5 write count", wrCount - w0, setCnt);
      chk(!orderBad, "R5 ascending order", orderBad, 0);
      for (int s = 0; s < 4; s++) begin
        logic [6:0] a;
        a = {VECS[k].addr[6:2], 2'(s)};
        if (slotSet[s]) expMem[a] = slotVal[s];
        chk(shadow[a] === expMem[a], "R2 R3 R4 page contents", shadow[a], expMem[a]);
      end
      @(negedge clk);
    end

    // R7: bare stop after start, no bytes
    w0 = wrCount;
    pulseStart();
    pulseStop();
    chk(busy === 1'b0, "R7 empty stop busy", busy, 0);
    @(negedge clk);
    chk(wrCount == w0, "R7 empty stop writes", wrCount - w0, 0);

    // R9: start empties buffer
    w0 = wrCount;
    pulseStart();
    sendByte(7'h50, 8'h66);
    pulseStart();
    pulseStop();
    chk(busy === 1'b0, "R9 cleared by start busy", busy, 0);
    @(negedge clk);
    chk(wrCount == w0, "R9 cleared by start writes", wrCount - w0, 0);

    // R8: strobes during busy ignored
    w0 = wrCount;
    pulseStart();
    sendByte(7'h20, 8'h11);
    expMem[7'h20] = 8'h11;
    pulseStop();
    sendByte(7'h30, 8'h99);
    pulseStart();
    pulseStop();
    measureBusy(len);
    chk(len == BUSY_LEN - 3, "R8 busy not extended", len, BUSY_LEN - 3);
    chk(wrCount - w0 == 1, "R8 single write", wrCount - w0, 1);
    chk(shadow[7'h30] === expMem[7'h30], "R8 busy byte not written", shadow[7'h30], expMem[7'h30]);
    chk(shadow[7'h20] === 8'h11, "R8 committed byte", shadow[7'h20], 8'h11);

    // R10: stop again after commit, no new bytes
    w0 = wrCount;
    pulseStop();
    chk(busy === 1'b0, "R10 repeat stop busy", busy, 0);
    @(negedge clk);
    chk(wrCount == w0, "R10 repeat stop writes", wrCount - w0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule